// File: doc/BRIEF.md
# Serial Isolation Engine

This block is the card-side half of a bus-wide identification game. It hands a unique card select number to every card that does not yet hold one. Each card carries a fixed serial identifier, `ID_W` bits wide. All cards taking part start together on a round-start strobe. They then shift their identifiers out one bit per slot, most significant bit first, onto one shared wired-OR line.

A card asserts the line only for a 1. For a 0 it leaves the line released. After each bit it listens to the line. A card that sent 0 but heard 1 knows a higher identifier is present, so it stays silent for the rest of the round. Every bit slot is made of two halves, each opened by a `half_tick` strobe. A card with a 1 asserts the line in both halves, and a bit is heard as 1 only when the line was sensed high in both halves. Noise in a single half therefore cannot knock a card out.

The card that survives the last bit raises `won` and waits for the host to present a handle. Once it latches a nonzero handle it raises `done`. From then on it ignores every later round and never asserts the line again. Cards that lost a round rejoin at the next round start.

States:
- `ST_IDLE`: after reset, waiting for a round.
- `ST_HALF_A`: first half of a bit slot.
- `ST_HALF_B`: second half of a bit slot.
- `ST_OUT`: dropped for the rest of the current round.
- `ST_WON`: survived the final bit and awaits a handle.
- `ST_DONE`: holds a handle, permanently.

Transitions:
- `round_start` in any state except `ST_DONE` (and except `ST_WON` with a valid load) goes to `ST_HALF_A` at the most significant bit.
- `half_tick` moves `ST_HALF_A` to `ST_HALF_B`.
- `half_tick` in `ST_HALF_B` goes to `ST_OUT` on a loss. Otherwise it goes to `ST_WON` after bit 0, or back to `ST_HALF_A` for the next lower bit.
- A nonzero load in `ST_WON` goes to `ST_DONE`.

Top module: `serial_isolation_engine`

## Requirements
- R1: After reset `won`, `done` and `wire_drive` are low and `csn` is zero.
- R2: During a round, in both halves of the slot for bit k (bits sent from `ID_W-1` down to 0), `wire_drive` is high exactly when the card is still in the round and `serial_id[k]` is 1.
- R3: A card that sends 0 in a slot and senses the line high in both halves drops out. It keeps `wire_drive` low for the rest of the round and does not raise `won` at its end. If every remaining card drops, no card wins.
- R4: The line sensed high in only one half of a slot counts as a heard 0 and drops no card.
- R5: After the last slot's second `half_tick`, `won` is high (from the next cycle) only on the card that never dropped. Without noise this is the participating card with the highest identifier.
- R6: While `won` is high, `csn_load` with a nonzero `csn_value` latches the handle into `csn`, raises `done` and clears `won`. A zero value is ignored.
- R7: `csn_load` in any state other than the won state leaves `csn` and `done` unchanged.
- R8: A card with `done` high ignores `round_start`. It never drives the line, never raises `won`, and keeps its handle until reset.
- R9: Cards that dropped out and still lack a handle take part again from the most significant bit at the next `round_start`, until every card holds a handle.
- R10: `round_start` in the middle of a round restarts the card at the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_id | input | ID_W | Fixed identifier of this card |
| round_start | input | 1 | One-cycle strobe that opens a round |
| half_tick | input | 1 | One-cycle strobe that closes each half of a bit slot |
| wire_sense | input | 1 | Sensed level of the shared line |
| wire_drive | output | 1 | Asserts the shared line (wired-OR) |
| csn_load | input | 1 | Handle offer strobe |
| csn_value | input | CSN_W | Offered handle |
| won | output | 1 | Card survived the last bit of the round |
| done | output | 1 | Card holds its handle |
| csn | output | CSN_W | Latched handle, zero when none |

## Verification
A bit pointer that is off by one shows as a drive pattern shifted by one slot on the very next half of a slot. It also lets a card with a lower identifier win, which `won` shows one cycle after the last tick. A wrong loss decision shows on the next slot as a missing or stray assertion of `wire_drive`. A card that leaves the finished state would drive the line in the first slot of the next round, and would show a changed `csn` at the ports. The bench runs several cards on one modelled line, so every such fault shows as a wrong winner or a wrong drive pattern within the same round.

// File: rtl/iso_pkg.sv
package iso_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALF_A,
        ST_HALF_B,
        ST_OUT,
        ST_WON,
        ST_DONE
    } iso_state_e;
endpackage

// File: rtl/iso_bit_pointer.sv
// Points at the identifier bit being sent; counts down from the top bit.
module iso_bit_pointer #(
    parameter int ID_W  = 72,
    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ID_W - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= TOP;
        end else if (restart) begin
            idx <= TOP;
        end else if (step && (idx != '0)) begin
            idx <= idx - 1'b1;
        end
    end

    assign last = (idx == '0);
endmodule

// File: rtl/iso_slot_judge.sv
// Decides, at the end of a slot, whether this card lost the bit.
module iso_slot_judge (
    input  logic my_bit,
    input  logic sense_a,
    input  logic sense_b,
    output logic lose
);
    logic heard_one;

    always_comb begin
        heard_one = sense_a & sense_b;
        lose      = ~my_bit & heard_one;
    end
endmodule

// File: rtl/iso_handle_reg.sv
// Holds the card select number once it is granted.
module iso_handle_reg #(
    parameter int CSN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CSN_W-1:0] value,
    output logic [CSN_W-1:0] csn
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn <= '0;
        end else if (load_en) begin
            csn <= value;
        end
    end
endmodule

// File: rtl/serial_isolation_engine.sv
module serial_isolation_engine
    import iso_pkg::*;
#(
    parameter int ID_W  = 72,
    parameter int CSN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  serial_id,
    input  logic             round_start,
    input  logic             half_tick,
    input  logic             wire_sense,
    output logic             wire_drive,
    input  logic             csn_load,
    input  logic [CSN_W-1:0] csn_value,
    output logic             won,
    output logic             done,
    output logic [CSN_W-1:0] csn
);
    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

    iso_state_e       state_q, state_nx;
    logic [IDX_W-1:0] bit_idx;
    logic             bit_last;
    logic             sense_a_q;
    logic             my_bit;
    logic             lose;
    logic             load_en;
    logic             begin_round;
    logic             ptr_step;

    iso_bit_pointer #(.ID_W(ID_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (begin_round),
        .step    (ptr_step),
        .idx     (bit_idx),
        .last    (bit_last)
    );

    iso_slot_judge u_judge (
        .my_bit  (my_bit),
        .sense_a (sense_a_q),
        .sense_b (wire_sense),
        .lose    (lose)
    );

    iso_handle_reg #(.CSN_W(CSN_W)) u_handle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .value   (csn_value),
        .csn     (csn)
    );

    assign my_bit = serial_id[bit_idx];

    // First-half sample of the shared line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_a_q <= 1'b0;
        end else if ((state_q == ST_HALF_A) && half_tick) begin
            sense_a_q <= wire_sense;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state and control strobes
    always_comb begin
        load_en     = (state_q == ST_WON) && csn_load && (csn_value != '0);
        begin_round = round_start && (state_q != ST_DONE) && !load_en;
        ptr_step    = (state_q == ST_HALF_B) && half_tick && !lose
                      && !bit_last && !begin_round;
        state_nx    = state_q;
        if (load_en) begin
            state_nx = ST_DONE;
        end else if (begin_round) begin
            state_nx = ST_HALF_A;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_HALF_A: if (half_tick) state_nx = ST_HALF_B;
                ST_HALF_B: begin
                    if (half_tick) begin
                        if (lose)          state_nx = ST_OUT;
                        else if (bit_last) state_nx = ST_WON;
                        else               state_nx = ST_HALF_A;
                    end
                end
                ST_OUT:    state_nx = ST_OUT;
                ST_WON:    state_nx = ST_WON;
                ST_DONE:   state_nx = ST_DONE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wire_drive = ((state_q == ST_HALF_A) || (state_q == ST_HALF_B)) && my_bit;
        won        = (state_q == ST_WON);
        done       = (state_q == ST_DONE);
    end
endmodule

// File: rtl/iso_engine_checker.sv
module iso_engine_checker #(
    parameter int CSN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             half_tick,
    input logic             wire_drive,
    input logic             csn_load,
    input logic             won,
    input logic             done,
    input logic [CSN_W-1:0] csn
);
    a_r8_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wire_drive);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(csn)));

    a_r6_done_has_handle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (csn != '0));

    a_r6_done_from_won: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(won) && $past(csn_load)));

    a_r7_csn_only_when_won: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csn) |-> ($past(won) && $past(csn_load)));

    a_r5_won_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(won) |-> $past(half_tick));

    a_r5_won_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(won && done));

    a_r5_won_silent: assert property (@(posedge clk) disable iff (!rst_n)
        won |-> !wire_drive);
endmodule

bind serial_isolation_engine iso_engine_checker #(.CSN_W(CSN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .wire_drive (wire_drive),
    .csn_load   (csn_load),
    .won        (won),
    .done       (done),
    .csn        (csn)
);

// File: tb/serial_isolation_engine_tb.sv
`timescale 1ns/1ps
module serial_isolation_engine_tb;
    localparam int ID_W  = 72;
    localparam int CSN_W = 8;
    localparam int NC    = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, round_start, half_tick, force_wire;
    logic [ID_W-1:0]   ids [NC];
    logic [NC-1:0]     drv, won_v, done_v, load_v;
    logic [CSN_W-1:0]  csn_val;
    logic [CSN_W-1:0]  csn_o [NC];
    logic              sense;

    assign sense = (|drv) | force_wire;

    for (genvar g = 0; g < NC; g++) begin : g_card
        serial_isolation_engine #(.ID_W(ID_W), .CSN_W(CSN_W)) u_dut (
            .clk         (clk),
            .rst_n       (rst_n),
            .serial_id   (ids[g]),
            .round_start (round_start),
            .half_tick   (half_tick),
            .wire_sense  (sense),
            .wire_drive  (drv[g]),
            .csn_load    (load_v[g]),
            .csn_value   (csn_val),
            .won         (won_v[g]),
            .done        (done_v[g]),
            .csn         (csn_o[g])
        );
    end

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit               has_csn [NC];
    logic [CSN_W-1:0] exp_csn [NC];
    int               next_handle;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int max_idx();
        int m = -1;
        for (int i = 0; i < NC; i++)
            if (!has_csn[i] && (m < 0 || ids[i] > ids[m])) m = i;
        return m;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; round_start = 0; half_tick = 0; force_wire = 0;
        load_v = '0; csn_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            has_csn[i] = 0;
            exp_csn[i] = '0;
        end
        next_handle = 1;
        chk("R1 won after reset", won_v, '0);
        chk("R1 done after reset", done_v, '0);
        chk("R1 drive after reset", drv, '0);
        for (int i = 0; i < NC; i++) chk("R1 csn after reset", csn_o[i], '0);
    endtask

    task automatic tick(input logic f);
        half_tick = 1'b1; force_wire = f;
        @(negedge clk);
        half_tick = 1'b0; force_wire = 1'b0;
        @(negedge clk);
    endtask

    // Opens a round and abandons it after nbits slots (R10 setup)
    task automatic partial_round(input int nbits);
        @(negedge clk) round_start = 1'b1;
        @(negedge clk) round_start = 1'b0;
        for (int k = 0; k < 2 * nbits; k++) tick(1'b0);
    endtask

    // noise_mode: 0 none, 1 line forced in first half only, 2 both halves
    task automatic run_round(input int noise_bit, input int noise_mode,
                             input string tag, output int winner);
        logic [NC-1:0] active;
        logic [NC-1:0] exp_won;
        int e2 = 0;
        int e8 = 0;
        @(negedge clk) round_start = 1'b1;
        @(negedge clk) round_start = 1'b0;
        for (int i = 0; i < NC; i++) active[i] = !has_csn[i];
        for (int k = ID_W - 1; k >= 0; k--) begin
            logic fa, fb, orb, heard;
            fa = (k == noise_bit) && (noise_mode != 0);
            fb = (k == noise_bit) && (noise_mode == 2);
            for (int h = 0; h < 2; h++) begin
                for (int i = 0; i < NC; i++)
                    if (drv[i] !== (active[i] & ids[i][k])) begin
                        if (has_csn[i]) e8++; else e2++;
                    end
                tick(h == 0 ? fa : fb);
            end
            orb = 1'b0;
            for (int i = 0; i < NC; i++) orb = orb | (active[i] & ids[i][k]);
            heard = (orb | fa) & (orb | fb);
            for (int i = 0; i < NC; i++)
                if (active[i] && !ids[i][k] && heard) active[i] = 1'b0;
        end
        chk({tag, " R2 and R3 drive pattern"}, e2, 0);
        chk({tag, " R8 handled card silent"}, e8, 0);
        if (noise_mode == 2) begin
            exp_won = active;
        end else begin
            exp_won = '0;
            if (max_idx() >= 0) exp_won[max_idx()] = 1'b1;
        end
        chk({tag, " R5 won flags"}, won_v, exp_won);
        winner = -1;
        for (int i = 0; i < NC; i++) if (exp_won[i]) winner = i;
    endtask

    task automatic assign_handle(input int w);
        int j = -1;
        if (w < 0) return;
        for (int i = 0; i < NC; i++) if (i != w && !has_csn[i] && j < 0) j = i;
        if (j >= 0) begin
            @(negedge clk) begin load_v[j] = 1'b1; csn_val = 8'hA5; end
            @(negedge clk) load_v = '0;
            chk("R7 load to non-won card done", done_v[j], 1'b0);
            chk("R7 load to non-won card csn", csn_o[j], '0);
        end
        @(negedge clk) begin load_v[w] = 1'b1; csn_val = '0; end
        @(negedge clk) load_v = '0;
        chk("R6 zero handle keeps won", won_v[w], 1'b1);
        chk("R6 zero handle no done", done_v[w], 1'b0);
        @(negedge clk) begin load_v[w] = 1'b1; csn_val = CSN_W'(next_handle); end
        @(negedge clk) load_v = '0;
        chk("R6 done after load", done_v[w], 1'b1);
        chk("R6 csn latched", csn_o[w], CSN_W'(next_handle));
        chk("R6 won cleared", won_v[w], 1'b0);
        has_csn[w] = 1;
        exp_csn[w] = CSN_W'(next_handle);
        next_handle++;
    endtask

    task automatic finish_all(input bit rnd);
        int w;
        int cnt;
        for (int r = 0; r < NC + 2; r++) begin
            int nb = -1;
            int nm = 0;
            cnt = 0;
            for (int i = 0; i < NC; i++) if (has_csn[i]) cnt++;
            if (cnt == NC) break;
            if (rnd) begin
                nm = int'($urandom % 2);
                nb = int'($urandom % ID_W);
            end
            run_round(nb, nm, nm == 1 ? "R4 half noise" : "R9 round", w);
            assign_handle(w);
        end
        chk("R9 all cards done", done_v, {NC{1'b1}});
        for (int i = 0; i < NC; i++) chk("R8 handle kept", csn_o[i], exp_csn[i]);
    endtask

    initial begin
        int w;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NC; i++) ids[i] = '0;
        do_reset();

        // Directed set: ties down to the low bit, and an all-zero identifier
        ids[0] = '0;
        ids[1] = ID_W'(1);
        ids[2] = {1'b1, {(ID_W-1){1'b0}}};
        ids[3] = {1'b1, {(ID_W-2){1'b0}}, 1'b1};
        @(negedge clk) begin load_v[0] = 1'b1; csn_val = 8'h33; end
        @(negedge clk) load_v = '0;
        chk("R7 load while idle done", done_v[0], 1'b0);
        chk("R7 load while idle csn", csn_o[0], '0);
        partial_round(3);
        run_round(-1, 0, "R10 restart", w);
        assign_handle(w);
        finish_all(1'b0);

        // Forced line in both halves at the top bit drops every card
        do_reset();
        ids[0] = ID_W'(5); ids[1] = ID_W'(6); ids[2] = ID_W'(8); ids[3] = ID_W'(7);
        run_round(ID_W - 1, 2, "R3 all dropped", w);
        chk("R3 no winner", w, -1);
        run_round(ID_W - 1, 1, "R4 half noise", w);
        chk("R4 winner is highest", w, 2);
        assign_handle(w);
        finish_all(1'b0);

        // Random campaigns with shared prefixes
        for (int c = 0; c < 3; c++) begin
            bit dup;
            do_reset();
            for (int i = 0; i < NC; i++) begin
                do begin
                    ids[i] = ID_W'({$urandom, $urandom, $urandom});
                    if (i > 0 && ($urandom % 2) == 1) ids[i][ID_W-1:8] = ids[0][ID_W-1:8];
                    dup = 0;
                    for (int j = 0; j < i; j++) if (ids[j] == ids[i]) dup = 1;
                end while (dup);
            end
            finish_all(1'b1);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule